// File: doc/BRIEF.md
# ASCII Hex Record Memory Loader

This block turns a stream of ASCII characters into memory writes. Characters arrive one per cycle over a valid/ready handshake. The parser looks for a record mark and then rebuilds each field of the record from pairs of hexadecimal characters. The fields are the byte count, the 16-bit load address, the record type, the payload bytes and a closing checksum byte. For every payload byte it pulses a write strobe, with the byte and its target address on a write port. The address starts at the load address and steps up by one for each byte.

The parser keeps a running modulo-256 sum of every byte it decodes from a record. If the sum is not zero when the record closes, a sticky checksum flag is raised. Any character inside a record that is not a hex digit raises a sticky format flag, and the parser goes back to looking for the next record mark. A record with a byte count of zero ends the load. The block then raises `done` and discards all further input until reset. A typical use is a boot-time loader that copies a text image from a UART stream into on-chip RAM.

Top module: `hexrec_loader`

## Requirements
- R1: While reset is held and on the first cycle after it, `wr_en`, `done`, `checksum_error` and `format_error` are all low.
- R2: A record begins only at the character 0x3A (':'). Any other character received outside a record causes no write and no error, including CR, LF, space, letters and hex digits.
- R3: After the mark the record has these fields, in order, each byte as two hex characters with the high nibble first: a 1-byte count N, a 2-byte address (high byte first), a 1-byte type, N payload bytes and a 1-byte checksum.
- R4: Payload byte k (counting from 0) is written to address load_address + k. `wr_en` is high for exactly one cycle, the cycle after the edge that accepts the byte's second character.
- R5: The digits 0-9, A-F and a-f are all accepted as hex digits, and a letter decodes to the same value in either case.
- R6: A character inside a record that is not a hex digit (a second ':' included) sets `format_error` on the following cycle. The record is abandoned, and hex digits after it cause no writes until the next ':'. `format_error` is cleared only by reset.
- R7: The modulo-256 sum of count, both address bytes, type, all payload bytes and the checksum must be 0. If it is not, `checksum_error` rises on the cycle after the checksum's second character, and stays high until reset.
- R8: Payload writes are issued as each byte completes, so a record with a bad checksum still writes all of its bytes.
- R9: A record with count 0 raises `done` on the cycle after its checksum completes. After that, no character causes a write or changes either error flag until reset.
- R10: `ch_ready` is always high. A cycle with `ch_valid` low does not advance the parser and causes no write in the next cycle.
- R11: The write address wraps from 0xFFFF to 0x0000 within a record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_data | input | 8 | ASCII character |
| ch_valid | input | 1 | Character present this cycle |
| ch_ready | output | 1 | Character accepted (always high) |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | 8 | Write data |
| wr_en | output | 1 | One-cycle write strobe |
| done | output | 1 | Zero-count record seen; input is now discarded |
| checksum_error | output | 1 | Sticky: a record's sum was not zero |
| format_error | output | 1 | Sticky: non-hex character inside a record |

## Verification
Every result is registered exactly once after the edge that accepts the character that causes it. A payload write appears in the cycle after its second nibble. `checksum_error` and `done` appear in the cycle after the checksum's low nibble, and `format_error` in the cycle after the bad character. The bench drives each character at a falling edge and samples all outputs at the next falling edge, which is one accepting edge later. This lines each check up with that single register stage. A monitor sampling at every falling edge pops the expected write for each `wr_en` it sees. It therefore catches a missing, extra or late strobe as well as a wrong address or byte.

// File: rtl/hexrec_pkg.sv
package hexrec_pkg;

   typedef enum logic [2:0] {
      ST_HUNT,
      ST_LEN,
      ST_ADDR,
      ST_TYPE,
      ST_DATA,
      ST_CSUM,
      ST_DONE
   } hexrec_state_e;

   localparam logic [7:0] REC_MARK = 8'h3A;
   localparam int         BYTE_W   = 8;

endpackage

// File: rtl/hexrec_nibble.sv
// Combinational ASCII to nibble decoder. Lower-case support is selected at elaboration.
module hexrec_nibble #(
   parameter bit ACCEPT_LOWER = 1'b1
) (
   input  logic [7:0] ch,
   output logic       is_hex,
   output logic [3:0] nib
);

   logic lower_ok;

   generate
      if (ACCEPT_LOWER) begin : g_lower
         assign lower_ok = 1'b1;
      end else begin : g_upper_only
         assign lower_ok = 1'b0;
      end
   endgenerate

   logic is_digit, is_upper, is_lower;

   always_comb begin
      is_digit = (ch >= 8'h30) && (ch <= 8'h39);
      is_upper = (ch >= 8'h41) && (ch <= 8'h46);
      is_lower = lower_ok && (ch >= 8'h61) && (ch <= 8'h66);
      is_hex   = is_digit || is_upper || is_lower;
      if (is_digit) begin
         nib = ch[3:0];
      end else if (is_upper || is_lower) begin
         nib = ch[3:0] + 4'd9;
      end else begin
         nib = 4'h0;
      end
   end

endmodule

// File: rtl/hexrec_sum.sv
// Running modulo-256 record sum.
module hexrec_sum #(
   parameter int SUM_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             add,
   input  logic [SUM_W-1:0] byte_in,
   output logic [SUM_W-1:0] sum_plus
);

   logic [SUM_W-1:0] sum_q;

   assign sum_plus = sum_q + byte_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum_q <= '0;
      end else if (clr) begin
         sum_q <= '0;
      end else if (add) begin
         sum_q <= sum_plus;
      end
   end

endmodule

// File: rtl/hexrec_addr_gen.sv
// Load-address register: high byte is held, low byte completes the load; steps per write.
module hexrec_addr_gen #(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_hi,
   input  logic              ld_lo,
   input  logic              step,
   input  logic [7:0]        byte_in,
   output logic [ADDR_W-1:0] addr_q
);

   localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

   logic [7:0]  hi_byte_q;
   logic [15:0] full_addr;

   assign full_addr = {hi_byte_q, byte_in};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_byte_q <= '0;
         addr_q    <= '0;
      end else begin
         if (ld_hi) begin
            hi_byte_q <= byte_in;
         end
         if (ld_lo) begin
            addr_q <= full_addr[ADDR_W-1:0];
         end else if (step) begin
            addr_q <= addr_q + ONE;
         end
      end
   end

endmodule

// File: rtl/hexrec_loader.sv
module hexrec_loader
   import hexrec_pkg::*;
#(
   parameter int ADDR_W       = 16,
   parameter bit ACCEPT_LOWER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        ch_data,
   input  logic              ch_valid,
   output logic              ch_ready,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [7:0]        wr_data,
   output logic              wr_en,
   output logic              done,
   output logic              checksum_error,
   output logic              format_error
);

   generate
      if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr_w
         $error("hexrec_loader: ADDR_W must lie in 1..16");
      end
   endgenerate

   localparam int CNT_W = BYTE_W;

   hexrec_state_e    state_q, state_d;
   logic             hi_q;
   logic [3:0]       nhi_q;
   logic [CNT_W-1:0] len_q, fcnt_q, fcnt_inc;

   logic             is_hex;
   logic [3:0]       nib;
   logic [7:0]       cur_byte;
   logic             in_rec, start, nib_ok, byte_done, bad_char;
   logic             ld_hi, ld_lo, wr_fire, cs_fire, cs_bad;
   logic [7:0]       sum_plus;
   logic [ADDR_W-1:0] addr_q;

   assign ch_ready = 1'b1;

   hexrec_nibble #(.ACCEPT_LOWER(ACCEPT_LOWER)) nib_i (
      .ch     (ch_data),
      .is_hex (is_hex),
      .nib    (nib)
   );

   assign in_rec    = (state_q == ST_LEN) || (state_q == ST_ADDR) || (state_q == ST_TYPE)
                   || (state_q == ST_DATA) || (state_q == ST_CSUM);
   assign start     = ch_valid && (state_q == ST_HUNT) && (ch_data == REC_MARK);
   assign nib_ok    = ch_valid && in_rec && is_hex;
   assign byte_done = nib_ok && hi_q;
   assign bad_char  = ch_valid && in_rec && !is_hex;
   assign cur_byte  = {nhi_q, nib};
   assign fcnt_inc  = fcnt_q + CNT_W'(1);

   assign ld_hi   = byte_done && (state_q == ST_ADDR) && (fcnt_q == '0);
   assign ld_lo   = byte_done && (state_q == ST_ADDR) && (fcnt_q != '0);
   assign wr_fire = byte_done && (state_q == ST_DATA);
   assign cs_fire = byte_done && (state_q == ST_CSUM);
   assign cs_bad  = cs_fire && (sum_plus != 8'h00);

   hexrec_sum #(.SUM_W(BYTE_W)) sum_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (start),
      .add      (byte_done),
      .byte_in  (cur_byte),
      .sum_plus (sum_plus)
   );

   hexrec_addr_gen #(.ADDR_W(ADDR_W)) addr_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_hi   (ld_hi),
      .ld_lo   (ld_lo),
      .step    (wr_fire),
      .byte_in (cur_byte),
      .addr_q  (addr_q)
   );

   always_comb begin
      state_d = state_q;
      if (start) begin
         state_d = ST_LEN;
      end else if (bad_char) begin
         state_d = ST_HUNT;
      end else if (byte_done) begin
         case (state_q)
            ST_LEN:  state_d = ST_ADDR;
            ST_ADDR: if (fcnt_q != '0) state_d = ST_TYPE;
            ST_TYPE: state_d = (len_q == '0) ? ST_CSUM : ST_DATA;
            ST_DATA: if (fcnt_inc == len_q) state_d = ST_CSUM;
            ST_CSUM: state_d = (len_q == '0) ? ST_DONE : ST_HUNT;
            default: state_d = state_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_HUNT;
         hi_q    <= 1'b0;
         nhi_q   <= '0;
         len_q   <= '0;
         fcnt_q  <= '0;
      end else begin
         state_q <= state_d;
         if (start || bad_char || byte_done) begin
            hi_q <= 1'b0;
         end else if (nib_ok) begin
            hi_q  <= 1'b1;
            nhi_q <= nib;
         end
         if (byte_done && (state_q == ST_LEN)) begin
            len_q <= cur_byte;
         end
         if (start || (byte_done && (state_q == ST_LEN || state_q == ST_TYPE))) begin
            fcnt_q <= '0;
         end else if (byte_done && (state_q == ST_ADDR || state_q == ST_DATA)) begin
            fcnt_q <= fcnt_inc;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_en          <= 1'b0;
         wr_addr        <= '0;
         wr_data        <= '0;
         checksum_error <= 1'b0;
         format_error   <= 1'b0;
      end else begin
         wr_en <= wr_fire;
         if (wr_fire) begin
            wr_addr <= addr_q;
            wr_data <= cur_byte;
         end
         if (cs_bad) begin
            checksum_error <= 1'b1;
         end
         if (bad_char) begin
            format_error <= 1'b1;
         end
      end
   end

   assign done = (state_q == ST_DONE);

endmodule

// File: rtl/hexrec_loader_chk.sv
module hexrec_loader_chk (
   input logic clk,
   input logic rst_n,
   input logic ch_valid,
   input logic wr_en,
   input logic done,
   input logic checksum_error,
   input logic format_error
);

   assert_wr_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);

   assert_idle_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_valid |=> !wr_en);

   assert_no_write_when_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !wr_en);

   assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done);

   assert_cs_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      checksum_error |=> checksum_error);

   assert_fmt_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      format_error |=> format_error);

   assert_fmt_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(format_error) |-> $past(ch_valid));

endmodule

bind hexrec_loader hexrec_loader_chk chk_i (
   .clk            (clk),
   .rst_n          (rst_n),
   .ch_valid       (ch_valid),
   .wr_en          (wr_en),
   .done           (done),
   .checksum_error (checksum_error),
   .format_error   (format_error)
);

// File: tb/hexrec_loader_tb_top.sv
module hexrec_loader_tb_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  ch_data = 8'h00;
   logic        ch_valid = 1'b0;
   logic        ch_ready;
   logic [15:0] wr_addr;
   logic [7:0]  wr_data;
   logic        wr_en, done, checksum_error, format_error;

   int checks = 0;
   int fails  = 0;
   logic [23:0] exp_q[$];
   logic [7:0]  rec_q[$];
   logic [7:0]  bsum;
   string       mon_req = "R4";

   always #(CLK_PERIOD/2) clk = ~clk;

   hexrec_loader dut_i (
      .clk(clk), .rst_n(rst_n), .ch_data(ch_data), .ch_valid(ch_valid), .ch_ready(ch_ready),
      .wr_addr(wr_addr), .wr_data(wr_data), .wr_en(wr_en), .done(done),
      .checksum_error(checksum_error), .format_error(format_error)
   );

   task automatic chk_eq(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Write monitor: every strobe must match the next expected write.
   always @(negedge clk) begin
      if (rst_n && wr_en) begin
         checks++;
         if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL %s unexpected write: actual addr %0h data %0h expected none",
                     mon_req, wr_addr, wr_data);
         end else begin
            logic [23:0] e;
            e = exp_q.pop_front();
            if ({wr_addr, wr_data} != e) begin
               fails++;
               $display("FAIL %s write: actual %0h expected %0h", mon_req, {wr_addr, wr_data}, e);
            end
         end
      end
   end

   function automatic logic [7:0] hexc(input logic [3:0] n, input bit lower);
      if (n < 4'd10) return 8'h30 + {4'h0, n};
      return (lower ? 8'h61 : 8'h41) + {4'h0, n} - 8'd10;
   endfunction

   task automatic push_byte(input logic [7:0] b, input bit lower);
      rec_q.push_back(hexc(b[7:4], lower));
      rec_q.push_back(hexc(b[3:0], lower));
      bsum = bsum + b;
   endtask

   task automatic build_rec(input int len, input int addr, input int typ, input int seed,
                            input bit corrupt, input bit lower, input bit expect_wr);
      logic [7:0] cs;
      bsum = 8'h00;
      rec_q.push_back(8'h3A);
      push_byte(len[7:0], lower);
      push_byte(addr[15:8], lower);
      push_byte(addr[7:0], lower);
      push_byte(typ[7:0], lower);
      for (int k = 0; k < len; k++) begin
         logic [7:0]  b;
         logic [15:0] a;
         b = 8'((seed * 29 + k * 13 + 5) & 255);
         a = 16'((addr + k) & 16'hFFFF);
         push_byte(b, lower);
         if (expect_wr) exp_q.push_back({a, b});
      end
      cs = 8'h00 - bsum;
      if (corrupt) cs = cs ^ 8'h01;
      push_byte(cs, lower);
   endtask

   task automatic send_range(input int from, input int upto, input bit gaps);
      for (int i = from; i < upto; i++) begin
         @(negedge clk);
         ch_data  = rec_q[i];
         ch_valid = 1'b1;
         if (gaps) begin
            @(negedge clk);
            ch_valid = 1'b0;
         end
      end
      @(negedge clk);
      ch_valid = 1'b0;
   endtask

   task automatic send_all(input bit gaps);
      send_range(0, rec_q.size(), gaps);
      rec_q.delete();
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n    = 1'b0;
      ch_valid = 1'b0;
      exp_q.delete();
      rec_q.delete();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic chk_flags(input string req, input int cs, input int fmt, input int dn);
      chk_eq(req, "checksum_error", checksum_error, cs);
      chk_eq(req, "format_error", format_error, fmt);
      chk_eq(req, "done", done, dn);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end

   initial begin
      // R1: outputs during and right after reset
      repeat (2) @(negedge clk);
      chk_eq("R1", "wr_en in reset", wr_en, 0);
      chk_flags("R1", 0, 0, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk_eq("R1", "wr_en after reset", wr_en, 0);
      chk_flags("R1", 0, 0, 0);
      chk_eq("R10", "ch_ready", ch_ready, 1);

      // R2: junk between records is ignored
      mon_req = "R2";
      rec_q = '{8'h20, 8'h0D, 8'h0A, 8'h5A, 8'h31, 8'h32, 8'h41};
      send_all(1'b0);
      chk_flags("R2", 0, 0, 0);
      chk_eq("R2", "pending writes", exp_q.size(), 0);

      // R3 R4 R5: sweep of lengths, addresses and letter case
      mon_req = "R4";
      for (int len = 1; len <= 24; len++) begin
         build_rec(len, len * 16'h0123 + 16'h00A0, 0, len, 1'b0, len[0], 1'b1);
         rec_q.push_back(8'h0D);
         rec_q.push_back(8'h0A);
         send_all(1'b0);
         chk_eq("R3", "pending writes", exp_q.size(), 0);
         chk_flags("R5", 0, 0, 0);
      end

      // R11: address wrap
      mon_req = "R11";
      build_rec(4, 16'hFFFE, 0, 77, 1'b0, 1'b0, 1'b1);
      send_all(1'b0);
      chk_eq("R11", "pending writes", exp_q.size(), 0);

      // R10: gaps in ch_valid do not disturb parsing
      mon_req = "R10";
      build_rec(5, 16'h2468, 0, 9, 1'b0, 1'b1, 1'b1);
      send_all(1'b1);
      chk_eq("R10", "pending writes", exp_q.size(), 0);
      chk_eq("R10", "wr_en idle", wr_en, 0);
      chk_flags("R10", 0, 0, 0);

      // R7 R8: bad checksum, writes still happen, flag after last char, sticky
      mon_req = "R8";
      build_rec(3, 16'h1000, 0, 4, 1'b1, 1'b0, 1'b1);
      send_range(0, rec_q.size() - 1, 1'b0);
      chk_eq("R8", "pending writes", exp_q.size(), 0);
      chk_eq("R7", "checksum_error before last char", checksum_error, 0);
      send_range(rec_q.size() - 1, rec_q.size(), 1'b0);
      rec_q.delete();
      chk_eq("R7", "checksum_error after last char", checksum_error, 1);
      build_rec(2, 16'h2000, 0, 5, 1'b0, 1'b0, 1'b1);
      send_all(1'b0);
      chk_eq("R7", "checksum_error sticky", checksum_error, 1);
      chk_eq("R4", "pending writes", exp_q.size(), 0);

      // R6: bad character inside a record
      do_reset();
      mon_req = "R6";
      rec_q = '{8'h3A, 8'h30, 8'h33, 8'h30, 8'h30, 8'h47};
      send_all(1'b0);
      chk_flags("R6", 0, 1, 0);
      rec_q = '{8'h31, 8'h31, 8'h32, 8'h32, 8'h41, 8'h41, 8'h42, 8'h42, 8'h30, 8'h30};
      send_all(1'b0);
      chk_eq("R6", "pending writes", exp_q.size(), 0);
      build_rec(3, 16'h0040, 0, 6, 1'b0, 1'b0, 1'b1);
      send_all(1'b0);
      chk_eq("R6", "writes after resync", exp_q.size(), 0);
      chk_flags("R6", 0, 1, 0);
      // second colon inside a record is also a bad character
      do_reset();
      rec_q = '{8'h3A, 8'h30, 8'h3A};
      send_all(1'b0);
      chk_eq("R6", "colon inside record", format_error, 1);

      // R9: end-of-file record
      do_reset();
      mon_req = "R9";
      build_rec(2, 16'h0300, 0, 8, 1'b0, 1'b0, 1'b1);
      send_all(1'b0);
      build_rec(0, 16'h0000, 1, 0, 1'b0, 1'b0, 1'b0);
      send_range(0, rec_q.size() - 1, 1'b0);
      chk_eq("R9", "done before last char", done, 0);
      send_range(rec_q.size() - 1, rec_q.size(), 1'b0);
      rec_q.delete();
      chk_flags("R9", 0, 0, 1);
      build_rec(4, 16'h0500, 0, 3, 1'b0, 1'b0, 1'b0);
      build_rec(2, 16'h0600, 0, 3, 1'b1, 1'b0, 1'b0);
      rec_q.push_back(8'h3A);
      rec_q.push_back(8'h47);
      send_all(1'b0);
      chk_eq("R9", "pending writes", exp_q.size(), 0);
      chk_flags("R9", 0, 0, 1);

      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end

endmodule